// File: doc/BRIEF.md
# Compare-and-Skip Execution Unit

This unit executes the two conditional-skip instructions of a small 8-bit accumulator core. The first skips when a data-memory operand is above the working register. The second skips when the operand is below it. The unit decodes the presented 16-bit instruction word and forms a 12-bit data address from the 8-bit operand field, using either the access bank or the bank select register. It reads the operand through a combinational memory read port and compares it with the working register as an unsigned value. No status flag is changed.

A skip does not refetch. The instruction that has already been fetched behind the compare is turned into a NOP by asserting a flush output toward the fetch stage. If decode reports that the following instruction is two words long, the flush lasts a second cycle. The unit returns the address of the next instruction to execute and the number of cycles the compare consumed: one, two or three.

Top module: `cmpskip_unit`

## Requirements
- R1: Only words whose bits [15:9] equal 0110010 (skip-if-above) or 0110000 (skip-if-below) are executed. Any other word leaves done_o low on the following cycle.
- R2: When bit 8 of the word is 0, the operand address is the operand field itself if the field is below 0x60, and 0xF00 plus the field otherwise. The address is presented combinationally in the same cycle.
- R3: When bit 8 of the word is 1, the operand address is bank_sel_i in bits [11:8] and the operand field (bits [7:0]) in bits [7:0].
- R4: The skip-if-above instruction skips only when the operand, taken as unsigned, is strictly greater than wreg_i.
- R5: The skip-if-below instruction skips only when the operand, taken as unsigned, is strictly less than wreg_i. Equal operands never skip with either instruction.
- R6: An executed compare that does not skip gives done_o=1, skip_o=0, cycles_o=1 and pc_next_o=pc+1 on the next cycle, with no flush.
- R7: A skip over a one-word instruction gives skip_o=1, cycles_o=2 and pc_next_o=pc+2, and flush_o is high for exactly one cycle.
- R8: A skip over a two-word instruction gives cycles_o=3 and pc_next_o=pc+3, and flush_o is high for exactly two consecutive cycles.
- R9: A word presented while flush_o is high is discarded and not executed. done_o stays low on the next cycle.
- R10: After reset, done_o, skip_o and flush_o are 0, cycles_o is 0 and pc_next_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | An instruction word is presented this cycle |
| instr_word_i | input | 16 | Fetched instruction word |
| pc_i | input | 21 | Word address of the presented instruction |
| wreg_i | input | 8 | Working register value |
| bank_sel_i | input | 4 | Bank select register |
| next_is_dword_i | input | 1 | Decode reports that the following instruction is two words long |
| mem_addr_o | output | 12 | Data-memory read address |
| mem_rdata_i | input | 8 | Data-memory read data, combinational from mem_addr_o |
| done_o | output | 1 | A compare was executed in the previous cycle |
| skip_o | output | 1 | The executed compare skipped |
| flush_o | output | 1 | Turn the currently fetched instruction into a NOP |
| pc_next_o | output | 21 | Address of the next instruction to execute |
| cycles_o | output | 2 | Cycle count of the executed compare |

## Verification
The read address is combinational, so the bench checks mem_addr_o one time unit after driving the word, before the clock edge. done_o, skip_o, cycles_o and pc_next_o come from a single register stage and are due one edge after the word is presented. flush_o rises on that same edge and stays high for one or two cycles. A behavioural model in the bench advances once per clock and sets its expected values for every output. It compares them with the outputs shortly after each rising edge, so back-to-back words and words presented during a flush are judged in the correct cycle.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;

    localparam int OPND_W = 8;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SKIP_GT = 2'd1,
        OP_SKIP_LT = 2'd2
    } cs_op_e;

    // upper seven bits of the two instruction encodings
    localparam logic [6:0] ENC_SKIP_GT = 7'b0110010;
    localparam logic [6:0] ENC_SKIP_LT = 7'b0110000;

    function automatic cs_op_e decode_op(input logic [15:0] word);
        if (word[15:9] == ENC_SKIP_GT)
            return OP_SKIP_GT;
        else if (word[15:9] == ENC_SKIP_LT)
            return OP_SKIP_LT;
        else
            return OP_NONE;
    endfunction

endpackage

// File: rtl/cmpskip_decode.sv
module cmpskip_decode
    import cmpskip_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int ACCESS_SPLIT = 8'h60
) (
    input  logic [15:0]              word_i,
    input  logic [ADDR_W-OPND_W-1:0] bank_sel_i,
    output cs_op_e                   op_o,
    output logic [ADDR_W-1:0]        addr_o
);
    localparam int BANK_W = ADDR_W - OPND_W;

    logic [OPND_W-1:0] opnd;
    logic              banked;
    logic              low_half;

    always_comb begin
        op_o     = decode_op(word_i);
        opnd     = word_i[OPND_W-1:0];
        banked   = word_i[8];
        low_half = ({24'd0, opnd} < ACCESS_SPLIT);
        if (banked)
            addr_o = {bank_sel_i, opnd};
        else if (low_half)
            addr_o = {{BANK_W{1'b0}}, opnd};
        else
            addr_o = {{BANK_W{1'b1}}, opnd};
    end

endmodule

// File: rtl/cmpskip_compare.sv
module cmpskip_compare
    import cmpskip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  cs_op_e            op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] wreg_i,
    output logic              skip_cond_o
);
    logic [DATA_W:0] diff;
    logic            borrow;
    logic            zero;

    always_comb begin
        diff   = {1'b0, opnd_i} - {1'b0, wreg_i};
        borrow = diff[DATA_W];
        zero   = (diff[DATA_W-1:0] == '0);
        unique case (op_i)
            OP_SKIP_GT: skip_cond_o = !borrow && !zero;
            OP_SKIP_LT: skip_cond_o = borrow;
            default:    skip_cond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpskip_seq.sv
module cmpskip_seq #(
    parameter int PC_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic            skip_cond_i,
    input  logic            next_dword_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            done_o,
    output logic            skip_o,
    output logic            flush_o,
    output logic [1:0]      cycles_o,
    output logic [PC_W-1:0] pc_next_o
);
    typedef struct packed {
        logic            done;
        logic            skip;
        logic [1:0]      cycles;
        logic [1:0]      flush_cnt;
        logic [PC_W-1:0] pc;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [1:0] skip_words;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.skip   = 1'b0;
        st_d.cycles = 2'd0;
        skip_words  = skip_cond_i ? (next_dword_i ? 2'd2 : 2'd1) : 2'd0;
        if (st_q.flush_cnt != 2'd0) begin
            st_d.flush_cnt = st_q.flush_cnt - 2'd1;
        end else if (issue_i) begin
            st_d.done      = 1'b1;
            st_d.skip      = skip_cond_i;
            st_d.cycles    = 2'd1 + skip_words;
            st_d.flush_cnt = skip_words;
            st_d.pc        = pc_i + PC_W'(1) + PC_W'(skip_words);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done_o    = st_q.done;
    assign skip_o    = st_q.skip;
    assign flush_o   = st_q.flush_cnt != 2'd0;
    assign cycles_o  = st_q.cycles;
    assign pc_next_o = st_q.pc;

    assert_noskip_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !skip_o |-> cycles_o == 2'd1 && !flush_o);

    assert_skip_flushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && skip_o |-> flush_o);

    assert_dword_second_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && skip_o && cycles_o == 2'd3 |=> flush_o);

    assert_flush_max_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_o) && flush_o |=> !flush_o);

    assert_flush_discards_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o && issue_i |=> !done_o);

endmodule

// File: rtl/cmpskip_unit.sv
module cmpskip_unit
    import cmpskip_pkg::*;
#(
    parameter int PC_W         = 21,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 12,
    parameter int ACCESS_SPLIT = 8'h60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid_i,
    input  logic [15:0]              instr_word_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic [DATA_W-1:0]        wreg_i,
    input  logic [ADDR_W-OPND_W-1:0] bank_sel_i,
    input  logic                     next_is_dword_i,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    output logic                     done_o,
    output logic                     skip_o,
    output logic                     flush_o,
    output logic [PC_W-1:0]          pc_next_o,
    output logic [1:0]               cycles_o
);
    cs_op_e op;
    logic   skip_cond;
    logic   issue;

    cmpskip_decode #(.ADDR_W(ADDR_W), .ACCESS_SPLIT(ACCESS_SPLIT)) u_decode (
        .word_i     (instr_word_i),
        .bank_sel_i (bank_sel_i),
        .op_o       (op),
        .addr_o     (mem_addr_o)
    );

    cmpskip_compare #(.DATA_W(DATA_W)) u_compare (
        .op_i        (op),
        .opnd_i      (mem_rdata_i),
        .wreg_i      (wreg_i),
        .skip_cond_o (skip_cond)
    );

    assign issue = instr_valid_i && (op != OP_NONE);

    cmpskip_seq #(.PC_W(PC_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .skip_cond_i  (skip_cond),
        .next_dword_i (next_is_dword_i),
        .pc_i         (pc_i),
        .done_o       (done_o),
        .skip_o       (skip_o),
        .flush_o      (flush_o),
        .cycles_o     (cycles_o),
        .pc_next_o    (pc_next_o)
    );

    assert_pc_matches_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pc_next_o == $past(pc_i) + PC_W'(cycles_o));

    assert_other_words_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |=> !done_o);

endmodule

// File: tb/tb_cmpskip_unit.sv
module tb_cmpskip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [15:0] instr_word_i = '0;
    logic [20:0] pc_i = '0;
    logic [7:0]  wreg_i = '0;
    logic [3:0]  bank_sel_i = '0;
    logic        next_is_dword_i = 1'b0;
    logic [11:0] mem_addr_o;
    logic [7:0]  mem_rdata_i;
    logic        done_o, skip_o, flush_o;
    logic [20:0] pc_next_o;
    logic [1:0]  cycles_o;

    logic [7:0] mem [4096];
    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    int          m_flush = 0;
    bit          m_done = 0, m_skip = 0;
    int          m_cyc = 0;
    logic [20:0] m_pc = '0;

    always #2.5 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o];

    cmpskip_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_word_i(instr_word_i),
        .pc_i(pc_i), .wreg_i(wreg_i), .bank_sel_i(bank_sel_i), .next_is_dword_i(next_is_dword_i),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .done_o(done_o), .skip_o(skip_o),
        .flush_o(flush_o), .pc_next_o(pc_next_o), .cycles_o(cycles_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_addr(input logic [15:0] w, input logic [3:0] bs);
        if (w[8]) return {bs, w[7:0]};
        if (w[7:0] < 8'h60) return {4'h0, w[7:0]};
        return {4'hF, w[7:0]};
    endfunction

    task automatic compare_outputs(input string tag);
        chk(done_o == m_done, tag, "done", done_o, m_done);
        chk(skip_o == m_skip, tag, "skip", skip_o, m_skip);
        chk(flush_o == (m_flush != 0), tag, "flush", flush_o, m_flush != 0);
        chk(cycles_o == 2'(m_cyc), tag, "cycles", cycles_o, m_cyc);
        chk(pc_next_o == m_pc, tag, "pc_next", pc_next_o, m_pc);
    endtask

    task automatic step(input bit v, input logic [15:0] w, input logic [20:0] pc,
                        input logic [7:0] wr, input logic [3:0] bs, input bit dw,
                        input string tag);
        bit is_gt, is_lt, cond;
        int words;
        logic [11:0] a;
        instr_valid_i   = v;
        instr_word_i    = w;
        pc_i            = pc;
        wreg_i          = wr;
        bank_sel_i      = bs;
        next_is_dword_i = dw;
        #1;
        is_gt = (w[15:9] == 7'b0110010);
        is_lt = (w[15:9] == 7'b0110000);
        a = exp_addr(w, bs);
        if (v && (is_gt || is_lt))
            chk(mem_addr_o == a, tag, "addr", mem_addr_o, a);
        cond  = (is_gt && mem[a] > wr) || (is_lt && mem[a] < wr);
        words = cond ? (dw ? 2 : 1) : 0;
        m_done = 0; m_skip = 0; m_cyc = 0;
        if (m_flush != 0) begin
            m_flush--;
        end else if (v && (is_gt || is_lt)) begin
            m_done  = 1;
            m_skip  = cond;
            m_cyc   = 1 + words;
            m_pc    = pc + 21'(1 + words);
            m_flush = words;
        end
        @(posedge clk);
        #1;
        compare_outputs(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0000, 21'd0, 8'h00, 4'h0, 1'b0, tag);
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired R1 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) & 255);
        mem[12'h010] = 8'hFF;
        mem[12'h011] = 8'h00;
        mem[12'h05F] = 8'h80;
        mem[12'hF60] = 8'h10;
        mem[12'hFFF] = 8'h90;
        mem[12'h560] = 8'h42;
        mem[12'h5FF] = 8'h00;
        mem[12'h020] = 8'h55;

        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        compare_outputs("R10");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare_outputs("R10");

        // R5: equal operands never skip
        step(1'b1, 16'h6420, 21'd100, 8'h55, 4'h0, 1'b0, "R5");
        step(1'b1, 16'h6020, 21'd101, 8'h55, 4'h0, 1'b0, "R5");
        // R4 / R7: 0xFF above 0x00 skips over a one-word instruction
        step(1'b1, 16'h6410, 21'd200, 8'h00, 4'h0, 1'b0, "R7");
        idle("R7");
        idle("R7");
        // R4 / R6: 0x00 above 0xFF does not skip
        step(1'b1, 16'h6411, 21'd300, 8'hFF, 4'h0, 1'b0, "R6");
        // R5 / R8: 0x00 below 0xFF skips over a two-word instruction
        step(1'b1, 16'h6011, 21'd400, 8'hFF, 4'h0, 1'b1, "R8");
        // R9: words presented during the flush are discarded
        step(1'b1, 16'h6410, 21'd401, 8'h00, 4'h0, 1'b0, "R9");
        step(1'b1, 16'h6410, 21'd402, 8'h00, 4'h0, 1'b0, "R9");
        idle("R8");
        // R5: 0xFF below 0x00 does not skip
        step(1'b1, 16'h6010, 21'd500, 8'h00, 4'h0, 1'b1, "R5");
        // R2: access bank boundary
        step(1'b1, 16'h645F, 21'd600, 8'h7F, 4'h3, 1'b0, "R2");
        idle("R2"); idle("R2");
        step(1'b1, 16'h6060, 21'd610, 8'h20, 4'h3, 1'b0, "R2");
        idle("R2");
        step(1'b1, 16'h64FF, 21'd620, 8'hA0, 4'h3, 1'b1, "R2");
        // R3: banked addressing
        step(1'b1, 16'h6560, 21'd700, 8'h41, 4'h5, 1'b1, "R3");
        idle("R3"); idle("R3");
        step(1'b1, 16'h61FF, 21'd710, 8'h01, 4'h5, 1'b0, "R3");
        idle("R3");
        step(1'b1, 16'h6520, 21'd720, 8'h10, 4'h0, 1'b0, "R3");
        idle("R3");
        // R1: neighbouring encodings are not executed
        step(1'b1, 16'h6610, 21'd800, 8'h00, 4'h0, 1'b0, "R1");
        step(1'b1, 16'h6210, 21'd801, 8'h00, 4'h0, 1'b0, "R1");
        step(1'b1, 16'h7410, 21'd802, 8'h00, 4'h0, 1'b0, "R1");
        step(1'b1, 16'h2410, 21'd803, 8'h00, 4'h0, 1'b0, "R1");
        step(1'b0, 16'h6410, 21'd804, 8'h00, 4'h0, 1'b0, "R1");
        // R6: back-to-back non-skipping compares
        for (int k = 0; k < 6; k++)
            step(1'b1, 16'h6420, 21'(900 + k), 8'(8'h55 + k), 4'h0, 1'b0, "R6");
        idle("R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule